// File: doc/BRIEF.md
# Sixteen-bit Arithmetic-Logic Unit with Sign and Zero Status

This block is the arithmetic-logic unit of a small sixteen-bit processor, together with the status register that sits beside it. The result path is purely combinational. It takes a source operand, a destination operand that can also act as a pass-through path, and a three-bit operation selector, and it drives a sixteen-bit result in the same cycle.

The selector values match the processor's data-instruction opcodes, so the control unit can forward the opcode field without translating it. An eighth code passes the second operand through unchanged, which the sequencer uses for address and transfer steps.

The only flags are sign and zero. They are computed from the current result and are stored in the status register on a rising clock edge only while the load strobe is high. There is no carry or overflow flag, and sums and differences wrap modulo 2^16.

Top module: `alu_nz_unit`

## Requirements
- R1: Selector 3'b000 makes the result equal to the source operand (`src_a`).
- R2: Selector 3'b001 makes the result `src_a + dst_b` modulo 65536, and no carry is reported.
- R3: Selector 3'b010 makes the result the bitwise complement of `src_a`.
- R4: Selector 3'b011 makes the result `src_a & dst_b`.
- R5: Selector 3'b100 makes the result `{src_a[14:0], 1'b0}`.
- R6: Selector 3'b101 makes the result `{src_a[15], src_a[15:1]}`, so the sign bit is kept.
- R7: Selector 3'b110 makes the result `dst_b - src_a` modulo 65536.
- R8: Selector 3'b111 makes the result equal to `dst_b`.
- R9: When `ld_stat` is high at a rising clock edge, `flag_n` takes result bit 15 and `flag_z` takes 1 exactly when all sixteen result bits are zero. Both values appear one cycle after the edge.
- R10: When `ld_stat` is low at a rising clock edge, `flag_n` and `flag_z` keep their previous values.
- R11: When `rst_n` is low at a rising clock edge, both flags are cleared to 0. Reset takes priority over `ld_stat`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the status register |
| rst_n | input | 1 | Synchronous reset, active low |
| op_sel | input | 3 | Operation selector |
| src_a | input | 16 | Source operand |
| dst_b | input | 16 | Destination or pass-through operand |
| ld_stat | input | 1 | Strobe that loads the status flags |
| result | output | 16 | Combinational result |
| flag_n | output | 1 | Stored sign flag |
| flag_z | output | 1 | Stored zero flag |

## Verification
Every selector is driven with a set of corner operands as well as pseudo-random operands:
- Zero operands and all-ones operands show whether the zero flag and the wrap of the sum are correct.
- Operands with the sign bit set separate the arithmetic right shift from a logical shift.
- Operand pairs whose sum crosses 2^16, and differences that borrow, expose any carry leaking into the result.

Strobe patterns alternate loading and holding the flags, so a flag that follows the result without the strobe is told apart from a flag that is held correctly. Reset is asserted with the strobe high to confirm that reset wins.

// File: rtl/alu_nz_pkg.sv
// Package: shared opcode encoding and data width for the ALU and its status register.
// Assumes: the opcode values are the processor's data-instruction opcodes, plus sub and pass-B.
package alu_nz_pkg;
    localparam int unsigned DATA_W = 16;
    localparam int unsigned OP_W   = 3;

    typedef enum logic [OP_W-1:0] {
        OP_MOVE  = 3'b000,
        OP_ADD   = 3'b001,
        OP_INV   = 3'b010,
        OP_AND   = 3'b011,
        OP_SHL   = 3'b100,
        OP_ASHR  = 3'b101,
        OP_SUB   = 3'b110,
        OP_PASSB = 3'b111
    } alu_op_e;

    typedef struct packed {
        logic neg;
        logic zero;
    } nz_flags_t;
endpackage

// File: rtl/alu_nz_shift.sv
// Module: one-position shifter for the source operand.
// The left shift fills bit 0 with zero. The right shift replicates the top bit.
// Assumes: W >= 2.
module alu_nz_shift #(
    parameter int unsigned W = 16
) (
    input  logic [W-1:0] din,
    output logic [W-1:0] shl_out,
    output logic [W-1:0] ashr_out
);
    // Builds both shifted forms bit by bit.
    for (genvar i = 0; i < W; i++) begin : g_bit
        if (i == 0) begin : g_lo
            assign shl_out[i] = 1'b0;
        end else begin : g_hi
            assign shl_out[i] = din[i-1];
        end

        if (i == W-1) begin : g_top
            assign ashr_out[i] = din[W-1];
        end else begin : g_mid
            assign ashr_out[i] = din[i+1];
        end
    end
endmodule

// File: rtl/alu_nz_core.sv
// Module: combinational result selection over the eight operations.
// Assumes: the sum and difference wrap and drop the carry. There is no internal state.
module alu_nz_core
    import alu_nz_pkg::*;
#(
    parameter int unsigned W = DATA_W
) (
    input  logic [OP_W-1:0] op_sel,
    input  logic [W-1:0]    a,
    input  logic [W-1:0]    b,
    output logic [W-1:0]    y
);
    logic [W-1:0] sum_w;
    logic [W-1:0] dif_w;
    logic [W-1:0] shl_w;
    logic [W-1:0] ashr_w;

    // Wrapping adder and subtracter (destination minus source).
    assign sum_w = a + b;
    assign dif_w = b - a;

    alu_nz_shift #(.W(W)) u_shift (
        .din      (a),
        .shl_out  (shl_w),
        .ashr_out (ashr_w)
    );

    // Picks the result for the current selector.
    always_comb begin
        unique case (alu_op_e'(op_sel))
            OP_MOVE:  y = a;
            OP_ADD:   y = sum_w;
            OP_INV:   y = ~a;
            OP_AND:   y = a & b;
            OP_SHL:   y = shl_w;
            OP_ASHR:  y = ashr_w;
            OP_SUB:   y = dif_w;
            OP_PASSB: y = b;
            default:  y = a;
        endcase
    end
endmodule

// File: rtl/alu_nz_status.sv
// Module: sign and zero status register, loaded on a strobe.
// Assumes: synchronous active-low reset, which has priority over the load strobe.
module alu_nz_status
    import alu_nz_pkg::*;
#(
    parameter int unsigned W = DATA_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] res,
    output nz_flags_t    flags
);
    nz_flags_t next_w;

    // Derives the flag values from the current result.
    always_comb begin
        next_w.neg  = res[W-1];
        next_w.zero = (res == '0);
    end

    // Clears on reset, loads on the strobe, and holds otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)
            flags <= '0;
        else if (load)
            flags <= next_w;
    end
endmodule

// File: rtl/alu_nz_unit.sv
// Module: top level of the ALU with its stored sign and zero flags.
// Assumes: operands are stable around the clock edge on which ld_stat is sampled.
module alu_nz_unit
    import alu_nz_pkg::*;
#(
    parameter int unsigned W = DATA_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [OP_W-1:0] op_sel,
    input  logic [W-1:0]    src_a,
    input  logic [W-1:0]    dst_b,
    input  logic            ld_stat,
    output logic [W-1:0]    result,
    output logic            flag_n,
    output logic            flag_z
);
    nz_flags_t st_q;

    alu_nz_core #(.W(W)) u_core (
        .op_sel (op_sel),
        .a      (src_a),
        .b      (dst_b),
        .y      (result)
    );

    alu_nz_status #(.W(W)) u_stat (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (ld_stat),
        .res   (result),
        .flags (st_q)
    );

    // Exposes the stored flags as separate outputs.
    assign flag_n = st_q.neg;
    assign flag_z = st_q.zero;
endmodule

// File: rtl/alu_nz_unit_chk.sv
// Module: temporal checks on the ALU status behaviour, bound to the top module.
// Assumes: it is bound to alu_nz_unit with default parameters.
module alu_nz_unit_chk #(
    parameter int unsigned W = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic [2:0]   op_sel,
    input logic [W-1:0] src_a,
    input logic [W-1:0] dst_b,
    input logic         ld_stat,
    input logic [W-1:0] result,
    input logic         flag_n,
    input logic         flag_z
);
    // R11
    reset_clear_chk: assert property (@(posedge clk) !rst_n |=> (!flag_n && !flag_z));

    // R10
    hold_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ld_stat |=> ($stable(flag_n) && $stable(flag_z)));

    // R9
    neg_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ld_stat |=> (flag_n == $past(result[W-1])));

    // R9
    zero_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ld_stat |=> (flag_z == ($past(result) == '0)));

    // R8
    passb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_sel == 3'b111) |-> (result == dst_b));

    // R1
    move_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_sel == 3'b000) |-> (result == src_a));
endmodule

bind alu_nz_unit alu_nz_unit_chk #(.W(W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .op_sel  (op_sel),
    .src_a   (src_a),
    .dst_b   (dst_b),
    .ld_stat (ld_stat),
    .result  (result),
    .flag_n  (flag_n),
    .flag_z  (flag_z)
);

// File: tb/alu_nz_unit_bench.sv
// Bench: behavioural reference model, compared against the outputs on every cycle.
module alu_nz_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [2:0]  op_sel;
    logic [15:0] src_a;
    logic [15:0] dst_b;
    logic        ld_stat;
    logic [15:0] result;
    logic        flag_n;
    logic        flag_z;

    int checks   = 0;
    int failures = 0;
    bit done     = 0;

    // Reference model state for the stored flags.
    bit ref_n;
    bit ref_z;

    always #5 clk = ~clk;

    alu_nz_unit u_alu_nz_unit (
        .clk     (clk),
        .rst_n   (rst_n),
        .op_sel  (op_sel),
        .src_a   (src_a),
        .dst_b   (dst_b),
        .ld_stat (ld_stat),
        .result  (result),
        .flag_n  (flag_n),
        .flag_z  (flag_z)
    );

    // Reference result for one operation, computed with integer arithmetic.
    function automatic logic [15:0] model(input int op, input int a, input int b);
        int r;
        case (op)
            0: r = a;
            1: r = (a + b) % 65536;
            2: r = 65535 - a;
            3: r = a & b;
            4: r = (a * 2) % 65536;
            5: r = (a / 2) + ((a >= 32768) ? 32768 : 0);
            6: r = (b - a + 65536) % 65536;
            default: r = b;
        endcase
        return r[15:0];
    endfunction

    function automatic string rtag(input int op);
        case (op)
            0: return "R1";
            1: return "R2";
            2: return "R3";
            3: return "R4";
            4: return "R5";
            5: return "R6";
            6: return "R7";
            default: return "R8";
        endcase
    endfunction

    // Drives one cycle of stimulus, checks the result mid-cycle,
    // then checks the flags after the clock edge.
    task automatic step(input int op, input int a, input int b, input bit ld, input bit rs);
        logic [15:0] exp_r;
        @(negedge clk);
        op_sel  = op[2:0];
        src_a   = a[15:0];
        dst_b   = b[15:0];
        ld_stat = ld;
        rst_n   = rs;
        #1;
        exp_r = model(op, a, b);
        checks++;
        if (result !== exp_r) begin
            failures++;
            $display("FAIL %s result op=%0d act=%h exp=%h", rtag(op), op, result, exp_r);
        end
        if (!rs) begin
            ref_n = 0;
            ref_z = 0;
        end else if (ld) begin
            ref_n = exp_r[15];
            ref_z = (exp_r == 0);
        end
        @(posedge clk);
        #2;
        checks++;
        if (flag_n !== ref_n || flag_z !== ref_z) begin
            failures++;
            $display("FAIL %s flags act=%b%b exp=%b%b",
                     !rs ? "R11" : (ld ? "R9" : "R10"),
                     flag_n, flag_z, ref_n, ref_z);
        end
    endtask

    initial begin
        int seed = 7;
        rst_n = 0;
        op_sel = 0;
        src_a = 0;
        dst_b = 0;
        ld_stat = 0;

        // R11: reset clears the flags.
        step(0, 16'h8000, 0, 0, 0);
        // R11: reset wins over the load strobe.
        step(0, 16'h8000, 0, 1, 0);

        // Corner operands for every selector, loading and then holding the flags (R9, R10).
        for (int op = 0; op < 8; op++) begin
            step(op, 0, 0, 1, 1);
            step(op, 16'hFFFF, 16'hFFFF, 0, 1);
            step(op, 16'h8001, 16'h7FFF, 1, 1);
            step(op, 16'h0001, 16'hFFFF, 1, 1);
            step(op, 16'h4000, 16'h0000, 0, 1);
        end

        // R2: the sum wraps to zero.
        step(1, 16'h0001, 16'hFFFF, 1, 1);
        // R7: the difference borrows.
        step(6, 16'h0002, 16'h0001, 1, 1);
        // R6: the sign bit is kept by the right shift.
        step(5, 16'h8000, 0, 1, 1);
        // R5: the top bit is shifted out.
        step(4, 16'h8000, 0, 1, 1);
        // R10: the flags hold while the result changes.
        step(8'd2, 0, 0, 0, 1);

        // Pseudo-random operands with random strobes.
        for (int i = 0; i < 400; i++) begin
            int a;
            int b;
            int o;
            int l;
            a = $urandom(seed + i) % 65536;
            b = $urandom(seed * 3 + i) % 65536;
            o = $urandom(i + 11) % 8;
            l = $urandom(i + 99) % 2;
            step(o, a, b, l[0], 1);
        end

        // R11: reset in the middle of the run.
        step(0, 16'hFFFF, 0, 1, 0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // Watchdog: ends a hung run as a failure.
    initial begin
        #500000;
        if (!done) begin
            failures++;
            $display("FAIL watchdog act=timeout exp=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule